// File: doc/BRIEF.md
# Serial MII Transmit Segment Deserializer

This block sits on the PHY side of a source-synchronous serial MII link and turns the MAC's one-wire transmit stream back into parallel form. It samples a single serial line on the clock the MAC forwards with the data. A sync pulse, also driven by the MAC, marks where each 10-bit segment begins. Each segment holds the transmit-error flag, the transmit-enable flag and one data byte. The block presents the three fields in parallel, together with a one-cycle strobe for each byte it accepts.

At 100 Mbps every segment carries a new byte. At 10 Mbps the MAC sends each segment ten times in a row, and the block keeps only one copy out of each ten.

The block has no collision output. The MAC detects a collision itself by seeing carrier and its own transmit enable both asserted. Moving the recovered fields into the PHY core clock domain is left to the logic that uses this block.

Top module: `sermii_tx_deser`

## Requirements
- R1: Within a segment, bit position 0 is the error flag, position 1 is the enable flag, and positions 2 to 9 are data bits 0 to 7, least significant first. The accepted fields appear on `ctl_err`, `ctl_en` and `byte_out`.
- R2: The bit sampled in the same cycle as a high `seg_sync` is position 0 of a segment. With no further sync, the position count runs freely and a new segment starts every ten clocks.
- R3: A `seg_sync` that arrives while a segment is partly received, at any position other than 0, discards that partial segment. No strobe is issued for it, and a new segment starts at position 0 with the current bit.
- R4: `byte_strobe` is high for exactly one cycle, in the cycle right after the clock edge that samples position 9 of an accepted segment. The new field values appear in that same cycle.
- R5: With `slow_mode` low (100 Mbps), every complete segment is accepted.
- R6: With `slow_mode` high (10 Mbps), only one segment in ten is accepted. The accepted segment is the first complete one after lock, after a re-alignment, or after `slow_mode` rises following a re-alignment; after that, every tenth segment is accepted.
- R7: Between strobes, `ctl_err`, `ctl_en` and `byte_out` keep their last accepted values.
- R8: After reset and until the first `seg_sync`, all outputs stay zero and no strobe is issued, whatever `ser_bit` carries.
- R9: Two strobes are never less than ten cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Forwarded transmit clock from the MAC |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| seg_sync | input | 1 | Segment start marker driven by the MAC |
| ser_bit | input | 1 | Serial transmit data line |
| slow_mode | input | 1 | 1 selects 10 Mbps (one segment in ten used), 0 selects 100 Mbps |
| ctl_err | output | 1 | Recovered transmit-error flag |
| ctl_en | output | 1 | Recovered transmit-enable flag |
| byte_out | output | 8 | Recovered data byte |
| byte_strobe | output | 1 | One-cycle pulse marking a newly accepted byte |

## Verification
The assertions check on every cycle that:
- the outputs stay quiet until the first sync;
- the strobe is a single-cycle pulse;
- two strobes are at least ten cycles apart;
- the output fields do not change between strobes.

Other behaviours can only be shown by the bench's scenarios, which compare against expected values:
- that the right bit lands in each field;
- that the strobe falls in the exact cycle after the tenth bit;
- that a mid-segment sync throws away the partial segment;
- that slow mode keeps exactly the first of every ten segments.

// File: rtl/sermii_pkg.sv
package sermii_pkg;

  // Two control flags lead each segment, ahead of the data bits.
  localparam int CTRL_BITS = 2;
  localparam int ERR_POS   = 0;
  localparam int EN_POS    = 1;

  typedef enum logic {
    ALIGN_HUNT   = 1'b0,
    ALIGN_LOCKED = 1'b1
  } align_state_t;

endpackage

// File: rtl/sermii_align.sv
module sermii_align
  import sermii_pkg::*;
#(
  parameter int SEG_BITS = 10,
  parameter int POS_W    = $clog2(SEG_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  output logic             cap_en_o,
  output logic [POS_W-1:0] cap_idx_o,
  output logic             seg_done_o,
  output logic             realign_o
);

  localparam logic [POS_W-1:0] POS_LAST  = POS_W'(SEG_BITS - 1);
  localparam logic [POS_W-1:0] POS_FIRST = '0;
  localparam logic [POS_W-1:0] POS_NEXT  = POS_W'(1);

  align_state_t     state_q, state_n;
  logic [POS_W-1:0] pos_q, pos_n;
  logic             locked;

  assign locked = (state_q == ALIGN_LOCKED);

  // Next-state logic.
  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    if (sync_i) begin
      // The bit sampled in this cycle is position 0, so the next one is position 1.
      state_n = ALIGN_LOCKED;
      pos_n   = POS_NEXT;
    end else if (locked) begin
      if (pos_q == POS_LAST) begin
        pos_n = POS_FIRST;
      end else begin
        pos_n = pos_q + POS_NEXT;
      end
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ALIGN_HUNT;
      pos_q   <= POS_FIRST;
    end else begin
      state_q <= state_n;
      pos_q   <= pos_n;
    end
  end

  assign cap_en_o   = sync_i | locked;
  assign cap_idx_o  = sync_i ? POS_FIRST : pos_q;
  assign seg_done_o = locked & ~sync_i & (pos_q == POS_LAST);
  assign realign_o  = sync_i & locked & (pos_q != POS_FIRST);

endmodule

// File: rtl/sermii_seg_capture.sv
module sermii_seg_capture #(
  parameter int SEG_BITS = 10,
  parameter int POS_W    = $clog2(SEG_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en_i,
  input  logic [POS_W-1:0]    cap_idx_i,
  input  logic                bit_i,
  output logic [SEG_BITS-1:0] seg_o
);

  localparam int HELD = SEG_BITS - 1;

  // The last bit is never stored: when it arrives, it goes straight to the output register.
  logic [HELD-1:0] held_q, held_n;

  for (genvar g = 0; g < HELD; g++) begin : g_slot
    always_comb begin
      held_n[g] = held_q[g];
      if (cap_en_i && (cap_idx_i == POS_W'(g))) begin
        held_n[g] = bit_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      held_q <= held_n;
    end
  end

  assign seg_o = {bit_i, held_q};

endmodule

// File: rtl/sermii_rep_gate.sv
module sermii_rep_gate #(
  parameter int REP_COUNT = 10,
  parameter int REP_W     = (REP_COUNT > 1) ? $clog2(REP_COUNT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_i,
  input  logic realign_i,
  input  logic seg_done_i,
  output logic accept_o
);

  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REP_COUNT - 1);
  localparam logic [REP_W-1:0] REP_ONE  = REP_W'(1);

  logic [REP_W-1:0] rep_q, rep_n;

  always_comb begin
    rep_n = rep_q;
    if (!slow_i || realign_i) begin
      rep_n = '0;
    end else if (seg_done_i) begin
      if (rep_q == REP_LAST) begin
        rep_n = '0;
      end else begin
        rep_n = rep_q + REP_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
    end else begin
      rep_q <= rep_n;
    end
  end

  assign accept_o = seg_done_i & (~slow_i | (rep_q == '0));

endmodule

// File: rtl/sermii_tx_deser.sv
module sermii_tx_deser
  import sermii_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int REP_COUNT = 10
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              seg_sync,
  input  logic              ser_bit,
  input  logic              slow_mode,
  output logic              ctl_err,
  output logic              ctl_en,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_strobe
);

  localparam int SEG_BITS = CTRL_BITS + DATA_W;
  localparam int POS_W    = $clog2(SEG_BITS);

  logic                cap_en;
  logic [POS_W-1:0]    cap_idx;
  logic                seg_done;
  logic                realign;
  logic                accept;
  logic [SEG_BITS-1:0] seg_w;
  logic [DATA_W-1:0]   data_w;

  sermii_align #(
    .SEG_BITS (SEG_BITS),
    .POS_W    (POS_W)
  ) u_align (
    .clk        (ser_clk),
    .rst_n      (rst_n),
    .sync_i     (seg_sync),
    .cap_en_o   (cap_en),
    .cap_idx_o  (cap_idx),
    .seg_done_o (seg_done),
    .realign_o  (realign)
  );

  sermii_seg_capture #(
    .SEG_BITS (SEG_BITS),
    .POS_W    (POS_W)
  ) u_capture (
    .clk       (ser_clk),
    .rst_n     (rst_n),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .bit_i     (ser_bit),
    .seg_o     (seg_w)
  );

  sermii_rep_gate #(
    .REP_COUNT (REP_COUNT)
  ) u_rep (
    .clk        (ser_clk),
    .rst_n      (rst_n),
    .slow_i     (slow_mode),
    .realign_i  (realign),
    .seg_done_i (seg_done),
    .accept_o   (accept)
  );

  for (genvar i = 0; i < DATA_W; i++) begin : g_data_map
    assign data_w[i] = seg_w[CTRL_BITS + i];
  end

  logic              err_q, err_n;
  logic              en_q, en_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              stb_q, stb_n;

  // Next-state logic for the output stage.
  always_comb begin
    stb_n  = accept;
    err_n  = err_q;
    en_n   = en_q;
    data_n = data_q;
    if (accept) begin
      err_n  = seg_w[ERR_POS];
      en_n   = seg_w[EN_POS];
      data_n = data_w;
    end
  end

  // Output registers.
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      en_q   <= 1'b0;
      data_q <= '0;
      stb_q  <= 1'b0;
    end else begin
      err_q  <= err_n;
      en_q   <= en_n;
      data_q <= data_n;
      stb_q  <= stb_n;
    end
  end

  assign ctl_err     = err_q;
  assign ctl_en      = en_q;
  assign byte_out    = data_q;
  assign byte_strobe = stb_q;

endmodule

// File: rtl/sermii_tx_deser_chk.sv
module sermii_tx_deser_chk #(
  parameter int DATA_W   = 8,
  parameter int SEG_BITS = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seg_sync,
  input logic              ctl_err,
  input logic              ctl_en,
  input logic [DATA_W-1:0] byte_out,
  input logic              byte_strobe
);

  localparam int GAP_W = $clog2(SEG_BITS + 1) + 1;
  localparam logic [GAP_W-1:0] GAP_MIN = GAP_W'(SEG_BITS);

  logic             seen_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      gap_q  <= GAP_MIN;
    end else begin
      if (seg_sync) seen_q <= 1'b1;
      if (byte_strobe) begin
        gap_q <= GAP_W'(1);
      end else if (gap_q < GAP_MIN) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end
  end

  // R8
  a_r8_quiet_before_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!byte_strobe && !ctl_err && !ctl_en && (byte_out == '0)));

  // R4
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |=> !byte_strobe);

  // R9
  a_r9_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_strobe |-> (gap_q >= GAP_MIN));

  // R7
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_strobe |-> ($stable(byte_out) && $stable(ctl_en) && $stable(ctl_err)));

endmodule

bind sermii_tx_deser sermii_tx_deser_chk #(
  .DATA_W   (DATA_W),
  .SEG_BITS (SEG_BITS)
) u_chk (
  .clk         (ser_clk),
  .rst_n       (rst_n),
  .seg_sync    (seg_sync),
  .ctl_err     (ctl_err),
  .ctl_en      (ctl_en),
  .byte_out    (byte_out),
  .byte_strobe (byte_strobe)
);

// File: tb/tb_sermii_tx_deser.sv
module tb_sermii_tx_deser;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seg_sync = 1'b0;
  logic       ser_bit = 1'b0;
  logic       slow_mode = 1'b0;
  logic       ctl_err;
  logic       ctl_en;
  logic [7:0] byte_out;
  logic       byte_strobe;

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "R8";

  // Expected outputs: the last accepted values, plus a flag for a strobe due at the next observation.
  logic       pend = 1'b0;
  logic       x_err = 1'b0;
  logic       x_en = 1'b0;
  logic [7:0] x_data = 8'h00;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sermii_tx_deser dut (
    .ser_clk     (clk),
    .rst_n       (rst_n),
    .seg_sync    (seg_sync),
    .ser_bit     (ser_bit),
    .slow_mode   (slow_mode),
    .ctl_err     (ctl_err),
    .ctl_en      (ctl_en),
    .byte_out    (byte_out),
    .byte_strobe (byte_strobe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // Sample at the falling edge, then drive the next bit.
  task automatic tick(input logic s, input logic b);
    @(negedge clk);
    chk(byte_strobe == pend, "R4 strobe", int'(byte_strobe), int'(pend));
    chk(byte_out == x_data, pend ? "R1 data" : "R7 data hold", int'(byte_out), int'(x_data));
    chk(ctl_en == x_en, pend ? "R1 enable" : "R7 enable hold", int'(ctl_en), int'(x_en));
    chk(ctl_err == x_err, pend ? "R1 error" : "R7 error hold", int'(ctl_err), int'(x_err));
    pend = 1'b0;
    seg_sync = s;
    ser_bit = b;
  endtask

  task automatic send_seg(input logic with_sync, input logic er, input logic en,
                          input logic [7:0] d, input bit acc);
    for (int i = 0; i < 10; i++) begin
      logic b;
      b = (i == 0) ? er : (i == 1) ? en : d[i-2];
      tick(with_sync && (i == 0), b);
    end
    if (acc) begin
      pend = 1'b1;
      x_err = er;
      x_en = en;
      x_data = d;
    end
  endtask

  // Sync followed by n-1 more bits, all ones, never completed.
  task automatic send_partial(input int n);
    tick(1'b1, 1'b1);
    for (int i = 1; i < n; i++) tick(1'b0, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    seg_sync = 1'b0;
    ser_bit = 1'b0;
    pend = 1'b0;
    x_err = 1'b0;
    x_en = 1'b0;
    x_data = 8'h00;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R8: reset state, then serial activity without any sync.
    phase = "R8";
    do_reset();
    for (int i = 0; i < 25; i++) tick(1'b0, logic'((i % 3) == 0));

    // R1 and R5: all flag and byte combinations at 100 Mbps.
    phase = "R1";
    for (int f = 0; f < 4; f++) begin
      for (int d = 0; d < 256; d++) begin
        send_seg(1'b1, logic'(f[1]), logic'(f[0]), 8'(d), 1'b1);
      end
    end
    tick(1'b0, 1'b0);

    // R2: segments that follow without a sync, with free-running alignment.
    phase = "R2";
    send_seg(1'b1, 1'b0, 1'b1, 8'h81, 1'b1);
    send_seg(1'b0, 1'b1, 1'b0, 8'h3C, 1'b1);
    send_seg(1'b0, 1'b0, 1'b1, 8'hE7, 1'b1);
    tick(1'b0, 1'b0);

    // R3: a sync in mid-segment throws away the partial segment.
    phase = "R3";
    send_seg(1'b1, 1'b0, 1'b1, 8'h5A, 1'b1);
    send_partial(4);
    send_seg(1'b1, 1'b0, 1'b1, 8'hC3, 1'b1);
    send_partial(9);
    send_seg(1'b1, 1'b1, 1'b0, 8'h0F, 1'b1);
    send_partial(1);
    send_seg(1'b1, 1'b0, 1'b0, 8'hA5, 1'b1);
    tick(1'b0, 1'b0);

    // R6: 10 Mbps keeps the first segment of each group of ten.
    phase = "R6";
    slow_mode = 1'b1;
    for (int k = 0; k < 35; k++) begin
      send_seg(1'b1, 1'b0, 1'b1, 8'(k * 7 + 1), (k % 10) == 0);
    end
    // R3 at 10 Mbps: re-alignment restarts the group of ten.
    send_partial(5);
    for (int j = 0; j < 12; j++) begin
      send_seg(1'b1, logic'(j[0]), 1'b1, 8'(j * 13 + 2), (j % 10) == 0);
    end
    tick(1'b0, 1'b0);

    // R5: back at 100 Mbps every segment is used again.
    phase = "R5";
    slow_mode = 1'b0;
    for (int k = 0; k < 5; k++) send_seg(1'b1, 1'b1, 1'b1, 8'(8'hF0 ^ k), 1'b1);
    tick(1'b0, 1'b0);

    // R8: after a mid-stream reset, data without any sync produces nothing.
    phase = "R8";
    do_reset();
    for (int k = 0; k < 3; k++) send_seg(1'b0, 1'b1, 1'b1, 8'hFF, 1'b0);
    tick(1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule